// File: doc/BRIEF.md
# Privilege and Banked Stack Controller

This block keeps the execution context of a small processor core: whether it runs application code (thread mode) or is servicing an exception (handler mode), whether that code is privileged, and which of two banked stack pointers is live. The core's sequencer drives strobes for exception entry, exception return and supervisor call. It also drives a two-bit control register write, and a push/pop port that turns stack operations into memory address, write data and strobe outputs.

In thread mode the control register decides privilege and stack choice. In handler mode the block forces privileged execution on the main stack. Only privileged code can change the control register. An unprivileged write is dropped and reported with a one-cycle error pulse. A supervisor call is the route back into privileged code. Both stacks are full descending. A push pre-decrements the pointer, and a pop reads at the pointer and then post-increments it, one 4-byte word at a time.

Top module: `ctx_exec_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`in_handler`=0) with `priv`=1, `ctl_q`=0 and `ctl_err`=0. The main pointer holds `main_sp_init` with its low two bits cleared, and the process pointer holds 0.
- R2: `exc_enter` puts the block in handler mode from the next cycle. `exc_return` puts it back in thread mode from the next cycle. When both are high, entry wins.
- R3: In handler mode `priv`=1 and `on_psp`=0, whatever `ctl_q` holds.
- R4: In thread mode, control bit 0 set to 1 makes execution unprivileged (`priv`=0). Control bit 1 set to 1 selects the process stack (`on_psp`=1).
- R5: A control write (`ctl_wr` with `ctl_wdata`) made while `priv`=1 is visible on `ctl_q` from the next cycle.
- R6: A control write made while `priv`=0 leaves `ctl_q` unchanged and raises `ctl_err` for exactly the next cycle.
- R7: `svc_req` enters handler mode from the next cycle, from either mode, so `priv`=1 from that cycle.
- R8: A push drives `mem_we`=1, `mem_wdata`=`push_data` and `mem_addr`=`act_sp`−4 in the same cycle. From the next cycle the active pointer equals that address.
- R9: A pop drives `mem_re`=1 and `mem_addr`=`act_sp` in the same cycle. From the next cycle the active pointer is `act_sp`+4.
- R10: When push and pop are both high, only the push is performed. Pointers wrap modulo 2^ADDR_W, and their low two bits are always zero.
- R11: A stack operation changes only the selected pointer. The other pointer keeps its value and shows it on `act_sp` once it is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_sp_init | input | ADDR_W | Main stack pointer value loaded at reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| svc_req | input | 1 | Supervisor call request |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data (bit0 unprivileged, bit1 process stack) |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | DATA_W | Item to stack |
| in_handler | output | 1 | 1 in handler mode |
| priv | output | 1 | Execution is privileged |
| on_psp | output | 1 | Process stack pointer is active |
| ctl_q | output | 2 | Control register value |
| ctl_err | output | 1 | One-cycle pulse after a rejected control write |
| act_sp | output | ADDR_W | Active stack pointer |
| sp_next | output | ADDR_W | Active pointer after this cycle's stack operation |
| mem_addr | output | ADDR_W | Stack memory address |
| mem_wdata | output | DATA_W | Stack write data |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |

## Verification
The bench sweeps all four control values. Each value is written from handler mode, entered through a supervisor call, and then exercised in thread mode with pushes, pops and a further control write. Two faults this catches are a handler that honours the control bits (an unprivileged handler, or one that pushes onto the process stack) and a write that slips through while unprivileged (`ctl_q` changes, or `ctl_err` stays low). The pointer cases are the push address taken before the decrement versus after it, the process pointer wrapping below zero, the simultaneous push and pop, and simultaneous entry and return. A wrong design would place items one word off, leave a misaligned reset pointer, or leave handler mode when it should stay.

// File: rtl/ctx_pkg.sv
// Package: shared types and constants for the execution context controller.
// Assumes a two-bit control register and exactly two banked stack pointers.
package ctx_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;

    localparam int CTL_W       = 2;
    localparam int NUM_BANKS   = 2;
    localparam int BANK_SEL_W  = $clog2(NUM_BANKS);
    localparam int BANK_MAIN   = 0;
    localparam int BANK_PROC   = 1;

    // Control register layout: bit1 = process stack select, bit0 = unprivileged.
    typedef struct packed {
        logic use_proc;
        logic unpriv;
    } ctl_t;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/ctx_mode_fsm.sv
// Module: ctx_mode_fsm
// Tracks thread versus handler mode. Entry and supervisor call move to
// handler mode and take priority over a return in the same cycle.
// Assumes strobes are single-cycle and already qualified by the core.
module ctx_mode_fsm
    import ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_enter,
    input  logic       exc_return,
    input  logic       svc_req,
    output exec_mode_e mode_q
);

    exec_mode_e mode_d;

    // Next-mode selection with entry winning over return.
    always_comb begin
        mode_d = mode_q;
        if (exc_enter || svc_req) begin
            mode_d = MODE_HANDLER;
        end else if (exc_return) begin
            mode_d = MODE_THREAD;
        end
    end

    // Mode register, thread mode out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_THREAD;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/ctx_ctrl_reg.sv
// Module: ctx_ctrl_reg
// Holds the control register and derives effective privilege and stack
// selection. Handler mode forces privileged and main stack. Writes are
// accepted only while privileged; a rejected write pulses err_q for one cycle.
module ctx_ctrl_reg
    import ctx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  exec_mode_e            mode,
    input  logic                  wr,
    input  ctl_t                  wdata,
    output ctl_t                  ctl_q,
    output logic                  priv,
    output logic [BANK_SEL_W-1:0] bank_sel,
    output logic                  err_q
);

    logic in_hnd;
    logic wr_ok;
    logic wr_bad;

    // Effective privilege and bank decode from mode and register.
    always_comb begin
        in_hnd   = (mode == MODE_HANDLER);
        priv     = in_hnd || !ctl_q.unpriv;
        bank_sel = (!in_hnd && ctl_q.use_proc) ? BANK_SEL_W'(BANK_PROC)
                                               : BANK_SEL_W'(BANK_MAIN);
        wr_ok    = wr && priv;
        wr_bad   = wr && !priv;
    end

    // Control register storage, updated only by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ok) begin
            ctl_q <= wdata;
        end
    end

    // One-cycle error pulse for a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= wr_bad;
        end
    end

endmodule

// File: rtl/ctx_stack_bank.sv
// Module: ctx_stack_bank
// Banked full-descending stack pointers. Push pre-decrements and writes at
// the new address; pop reads at the pointer then post-increments. Push wins
// over pop. Bank 0 loads an aligned init value at reset, other banks clear.
// Assumes STEP_BYTES is a power of two.
module ctx_stack_bank
    import ctx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     init_main,
    input  logic [BANK_SEL_W-1:0] sel,
    input  logic                  push,
    input  logic                  pop,
    input  logic [DATA_W-1:0]     push_data,
    output logic [ADDR_W-1:0]     act_sp,
    output logic [ADDR_W-1:0]     sp_next,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_we,
    output logic                  mem_re
);

    localparam logic [ADDR_W-1:0] STEP_V     = ADDR_W'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(STEP_BYTES - 1));

    logic [ADDR_W-1:0] bank_sp [NUM_BANKS];
    stk_op_e           op;

    // Decode the stack operation, push taking priority.
    always_comb begin
        if (push) begin
            op = STK_PUSH;
        end else if (pop) begin
            op = STK_POP;
        end else begin
            op = STK_IDLE;
        end
    end

    // Active pointer, next pointer and memory port for this cycle.
    always_comb begin
        act_sp    = bank_sp[sel];
        mem_wdata = push_data;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = act_sp;
        sp_next   = act_sp;
        case (op)
            STK_PUSH: begin
                sp_next  = (act_sp - STEP_V) & ALIGN_MASK;
                mem_addr = sp_next;
                mem_we   = 1'b1;
            end
            STK_POP: begin
                sp_next  = (act_sp + STEP_V) & ALIGN_MASK;
                mem_addr = act_sp;
                mem_re   = 1'b1;
            end
            default: begin
                sp_next  = act_sp;
            end
        endcase
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [ADDR_W-1:0] sp_q;
        logic              hit;

        // Bank is written only when selected and an operation occurs.
        always_comb begin
            hit = (sel == BANK_SEL_W'(g)) && (op != STK_IDLE);
        end

        // Pointer register for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                if (g == BANK_MAIN) begin
                    sp_q <= init_main & ALIGN_MASK;
                end else begin
                    sp_q <= '0;
                end
            end else if (hit) begin
                sp_q <= sp_next;
            end
        end

        assign bank_sp[g] = sp_q;
    end

endmodule

// File: rtl/ctx_exec_ctrl.sv
// Module: ctx_exec_ctrl (top)
// Execution context controller: mode tracking, privilege, control register
// and banked full-descending stack pointers. Instruction decode, exception
// arbitration and the memory itself live outside this block.
module ctx_exec_ctrl
    import ctx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] main_sp_init,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              svc_req,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_wdata,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic              in_handler,
    output logic              priv,
    output logic              on_psp,
    output logic [1:0]        ctl_q,
    output logic              ctl_err,
    output logic [ADDR_W-1:0] act_sp,
    output logic [ADDR_W-1:0] sp_next,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re
);

    exec_mode_e            mode;
    ctl_t                  ctl_r;
    ctl_t                  ctl_w;
    logic [BANK_SEL_W-1:0] bank_sel;

    // Map the flat write port onto the control structure.
    always_comb begin
        ctl_w = ctl_t'(ctl_wdata);
    end

    ctx_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .svc_req    (svc_req),
        .mode_q     (mode)
    );

    ctx_ctrl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .wr       (ctl_wr),
        .wdata    (ctl_w),
        .ctl_q    (ctl_r),
        .priv     (priv),
        .bank_sel (bank_sel),
        .err_q    (ctl_err)
    );

    ctx_stack_bank #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_main (main_sp_init),
        .sel       (bank_sel),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .act_sp    (act_sp),
        .sp_next   (sp_next),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    // Flatten internal state onto the output ports.
    always_comb begin
        in_handler = (mode == MODE_HANDLER);
        on_psp     = (bank_sel == BANK_SEL_W'(BANK_PROC));
        ctl_q      = ctl_r;
    end

endmodule

// File: rtl/ctx_exec_ctrl_chk.sv
// Module: ctx_exec_ctrl_chk
// Property checker for ctx_exec_ctrl, attached through bind below.
module ctx_exec_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_enter,
    input logic              exc_return,
    input logic              svc_req,
    input logic              ctl_wr,
    input logic              push,
    input logic              pop,
    input logic [DATA_W-1:0] push_data,
    input logic              in_handler,
    input logic              priv,
    input logic              on_psp,
    input logic [1:0]        ctl_q,
    input logic              ctl_err,
    input logic [ADDR_W-1:0] act_sp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_re
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

    logic quiet;
    assign quiet = !exc_enter && !exc_return && !svc_req && !ctl_wr;

    AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> in_handler); // R2
    AST_RETURN_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && !svc_req) |=> !in_handler); // R2
    AST_HANDLER_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter || svc_req) |=> (priv && !on_psp)); // R3
    AST_SVC_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> (in_handler && priv)); // R7
    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !priv) |=> ($stable(ctl_q) && ctl_err)); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> $past(ctl_wr && !priv)); // R6
    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (mem_we && !mem_re && mem_addr == act_sp - STEP_V && mem_wdata == push_data)); // R8
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (push && quiet) |=> (act_sp == $past(act_sp) - STEP_V)); // R8
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && quiet) |=> (act_sp == $past(act_sp) + STEP_V)); // R9
    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        act_sp[1:0] == 2'b00); // R10

endmodule

bind ctx_exec_ctrl ctx_exec_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STEP_BYTES (STEP_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .svc_req    (svc_req),
    .ctl_wr     (ctl_wr),
    .push       (push),
    .pop        (pop),
    .push_data  (push_data),
    .in_handler (in_handler),
    .priv       (priv),
    .on_psp     (on_psp),
    .ctl_q      (ctl_q),
    .ctl_err    (ctl_err),
    .act_sp     (act_sp),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
);

// File: tb/tb_ctx_exec_ctrl.sv
// Bench: sweeps control values and modes against an arithmetic model.
module tb_ctx_exec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] main_sp_init = 32'h2000_0103;
    logic        exc_enter = 0, exc_return = 0, svc_req = 0, ctl_wr = 0;
    logic [1:0]  ctl_wdata = 0;
    logic        push = 0, pop = 0;
    logic [31:0] push_data = 0;
    logic        in_handler, priv, on_psp, ctl_err, mem_we, mem_re;
    logic [1:0]  ctl_q;
    logic [31:0] act_sp, sp_next, mem_addr, mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state.
    logic [31:0] m_msp, m_psp;
    logic [1:0]  m_ctl;
    logic        m_hnd, m_err;

    always #5 clk = ~clk;

    ctx_exec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .main_sp_init(main_sp_init),
        .exc_enter(exc_enter), .exc_return(exc_return), .svc_req(svc_req),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .push(push), .pop(pop),
        .push_data(push_data), .in_handler(in_handler), .priv(priv),
        .on_psp(on_psp), .ctl_q(ctl_q), .ctl_err(ctl_err), .act_sp(act_sp),
        .sp_next(sp_next), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One cycle of stimulus with checks before and after the clock edge.
    task automatic cyc(input logic en, input logic ret, input logic sv, input logic wr,
                       input logic [1:0] wd, input logic pu, input logic po, input logic [31:0] d);
        logic        e_priv, e_psp;
        logic [31:0] cur, nxt;
        exc_enter = en; exc_return = ret; svc_req = sv; ctl_wr = wr;
        ctl_wdata = wd; push = pu; pop = po; push_data = d;
        #1;
        e_priv = m_hnd | ~m_ctl[0];
        e_psp  = ~m_hnd & m_ctl[1];
        cur    = e_psp ? m_psp : m_msp;
        if (m_hnd) begin
            chk(priv === 1'b1 && on_psp === 1'b0, "R3", {30'd0, priv, on_psp}, 32'h2);
        end else begin
            chk(priv === e_priv && on_psp === e_psp, "R4", {30'd0, priv, on_psp}, {30'd0, e_priv, e_psp});
        end
        chk(act_sp === cur, "R11", act_sp, cur);
        if (pu) begin
            nxt = cur - 32'd4;
            chk(mem_we === 1'b1 && mem_re === 1'b0 && mem_addr === nxt && mem_wdata === d,
                po ? "R10" : "R8", mem_addr, nxt);
        end else if (po) begin
            nxt = cur + 32'd4;
            chk(mem_re === 1'b1 && mem_we === 1'b0 && mem_addr === cur, "R9", mem_addr, cur);
        end else begin
            nxt = cur;
        end
        @(posedge clk);
        if (e_psp) m_psp = nxt; else m_msp = nxt;
        if (wr && e_priv) m_ctl = wd;
        m_err = wr && !e_priv;
        if (en || sv) m_hnd = 1'b1;
        else if (ret) m_hnd = 1'b0;
        #1;
        chk(in_handler === m_hnd, sv ? "R7" : "R2", {31'd0, in_handler}, {31'd0, m_hnd});
        chk(ctl_q === m_ctl, m_err ? "R6" : "R5", {30'd0, ctl_q}, {30'd0, m_ctl});
        chk(ctl_err === m_err, "R6", {31'd0, ctl_err}, {31'd0, m_err});
        chk(act_sp[1:0] === 2'b00, "R10", act_sp, {act_sp[31:2], 2'b00});
        exc_enter = 0; exc_return = 0; svc_req = 0; ctl_wr = 0; push = 0; pop = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_msp = 32'h2000_0100; m_psp = 32'h0; m_ctl = 2'b00; m_hnd = 1'b0; m_err = 1'b0;
        // R1: reset state
        chk(in_handler === 1'b0, "R1", {31'd0, in_handler}, 32'd0);
        chk(priv === 1'b1, "R1", {31'd0, priv}, 32'd1);
        chk(ctl_q === 2'b00 && ctl_err === 1'b0, "R1", {29'd0, ctl_err, ctl_q}, 32'd0);
        chk(act_sp === 32'h2000_0100, "R1", act_sp, 32'h2000_0100);
        // Main stack in privileged thread mode.
        cyc(0,0,0,0,2'b00,1,0,32'hA000_0001);
        cyc(0,0,0,0,2'b00,1,0,32'hA000_0002);
        cyc(0,0,0,0,2'b00,0,1,32'h0);
        cyc(0,0,0,0,2'b00,1,1,32'hA000_0003); // R10 push wins
        // Sweep every control value.
        for (int v = 0; v < 4; v++) begin
            cyc(0,0,1,0,2'b00,0,0,32'h0);                 // R7 supervisor call
            cyc(0,0,0,1,v[1:0],1,0,32'hB000_0000 + v);    // R5 write from handler
            cyc(0,0,0,0,2'b00,1,0,32'hB100_0000 + v);     // R3 handler on main
            cyc(0,1,0,0,2'b00,0,0,32'h0);                 // R2 return
            cyc(0,0,0,0,2'b00,1,0,32'hC000_0000 + v);
            cyc(0,0,0,0,2'b00,1,0,32'hC100_0000 + v);
            cyc(0,0,0,0,2'b00,0,1,32'h0);
            cyc(0,0,0,1,2'b11 ^ v[1:0],0,0,32'h0);        // R6 when unprivileged
            cyc(0,0,0,0,2'b00,0,1,32'h0);
            cyc(1,1,0,0,2'b00,0,0,32'h0);                 // R2 entry wins
            cyc(0,0,0,1,2'b00,0,0,32'h0);                 // restore control
            cyc(0,1,0,0,2'b00,0,0,32'h0);
        end
        // Process stack use after reaching it again from handler.
        cyc(1,0,0,1,2'b10,0,0,32'h0);
        cyc(0,1,0,0,2'b00,0,0,32'h0);
        cyc(0,0,0,0,2'b00,0,1,32'h0);                     // R11 process pointer kept
        cyc(0,0,0,0,2'b00,1,0,32'hD000_0001);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule